// File: doc/BRIEF.md
# Byte-to-halfword cell width matcher

This block takes a stream of 9-bit cell bytes, each marked by a start-of-cell flag on the first byte, and repacks them into 18-bit output words. In narrow mode it passes each byte through as a single word. In wide mode consecutive bytes are paired into one word. A swap control, sampled on every word, decides which 9-bit lane receives the first byte of each pair.

An optional edit function makes an 8-bit cell fit the 16-bit cell format. In transmit mode it removes the fifth byte of every cell. In receive mode it adds a zero byte so that the zero becomes the sixth byte. If the edited cell has an odd byte count, a zero pad fills the second half of its last word. The output marks the first word of each cell and flags the word that ends it. Handshake arbitration around the block is left to its neighbours.

Top module: `cell_width_matcher`

## Requirements
- R1: During and right after reset, out_valid, out_sop and out_eoc are low.
- R2: With bus_narrow=1, each accepted byte gives one word with the byte in out_word[8:0] and out_word[17:9]=0. lane_swap and edit_en have no effect in this mode.
- R3: With bus_narrow=0, each word holds two consecutive bytes of the edited cell. With lane_swap=1 the earlier byte sits in out_word[17:9]; with lane_swap=0 it sits in out_word[8:0].
- R4: lane_swap is sampled in the cycle that presents the byte completing a word, so a change affects the very next word produced.
- R5: With bus_narrow=0 and edit_en=0, no byte is added or removed. An odd cell gets one zero pad as the later byte of its last word.
- R6: With bus_narrow=0, edit_en=1 and tx_mode=1, the fifth byte of the cell (position 5, counting from 1) is dropped. A zero pad completes an odd result.
- R7: With bus_narrow=0, edit_en=1 and tx_mode=0, a zero byte is inserted right after the fifth input byte so that it becomes the sixth byte. A zero pad completes an odd result.
- R8: out_sop is high on the first word of each cell and out_eoc on its last. A cell yields ceil(edited bytes / 2) words in wide mode and one word per byte in narrow mode.
- R9: A valid byte outside a cell without in_sop is discarded. An in_sop inside a cell is ignored.
- R10: cell_bytes (a plain binary byte count, 8..128, at most 126 with edit_en=1), bus_narrow, edit_en and tx_mode are captured with the start-of-cell byte. Changes during the cell have no effect.
- R11: A word appears on the outputs exactly one clock after the input byte that completes it. out_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is present this cycle |
| in_sop | input | 1 | Marks the first byte of a cell |
| in_byte | input | 9 | Input byte |
| cell_bytes | input | 8 | Cell length in bytes, captured at start of cell |
| bus_narrow | input | 1 | 1: 9-bit pass-through, 0: 18-bit pairing |
| lane_swap | input | 1 | 1: first byte of a pair in the upper lane |
| edit_en | input | 1 | Enables byte delete or insert |
| tx_mode | input | 1 | 1: transmit (delete), 0: receive (insert) |
| out_valid | output | 1 | A word is present on out_word |
| out_word | output | 18 | Output word, upper lane [17:9], lower lane [8:0] |
| out_sop | output | 1 | First word of a cell |
| out_eoc | output | 1 | Last word of a cell |

## Verification
The hardest case is the parity flip that an edit causes partway through a cell. After the drop or the insertion, every later byte changes lane. Whether a final pad appears depends on both the cell's parity and the edit direction. To reach every combination, the bench sweeps cell lengths of both parities across all mode and edit settings, with idle gaps between bytes. During each cell it drives altered configuration values and a spurious start flag, and it flips lane_swap from byte to byte. This way a late capture or a wrong swap sampling point shows up in the words.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

    typedef struct packed {
        logic narrow;
        logic edit_en;
        logic tx;
    } cell_cfg_t;

endpackage

// File: rtl/cwm_cell_track.sv
module cwm_cell_track
    import cwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [CNT_W-1:0] cell_bytes,
    input  cell_cfg_t        cfg_in,
    output logic             accept,
    output logic [CNT_W-1:0] idx,
    output logic             last,
    output cell_cfg_t        cfg_o
);

    typedef struct packed {
        logic             in_cell;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] size;
        cell_cfg_t        cfg;
    } trk_t;

    trk_t             t_q, t_d;
    logic [CNT_W-1:0] cur_size;

    always_comb begin
        t_d      = t_q;
        cur_size = t_q.in_cell ? t_q.size : cell_bytes;
        cfg_o    = t_q.in_cell ? t_q.cfg  : cfg_in;
        idx      = t_q.in_cell ? t_q.idx  : '0;
        accept   = in_valid && (t_q.in_cell || in_sop);
        last     = (idx == (cur_size - CNT_W'(1)));
        if (accept) begin
            t_d.in_cell = !last;
            t_d.idx     = last ? '0 : idx + CNT_W'(1);
            t_d.size    = cur_size;
            t_d.cfg     = cfg_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (t_q.in_cell && $past(t_q.in_cell)) |-> (t_q.cfg == $past(t_q.cfg) && t_q.size == $past(t_q.size))); // R10

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        t_q.in_cell |-> (t_q.idx < t_q.size)); // R8

endmodule

// File: rtl/cwm_edit_plan.sv
module cwm_edit_plan
    import cwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DEL_POS = 5,
    parameter int INS_POS = 6
) (
    input  logic [CNT_W-1:0] idx,
    input  cell_cfg_t        cfg,
    output logic             drop,
    output logic             ins_after
);

    localparam logic [CNT_W-1:0] DEL_IDX = CNT_W'(DEL_POS - 1);
    localparam logic [CNT_W-1:0] INS_IDX = CNT_W'(INS_POS - 2);

    always_comb begin
        drop      = 1'b0;
        ins_after = 1'b0;
        if (cfg.edit_en && !cfg.narrow) begin
            if (cfg.tx) begin
                drop = (idx == DEL_IDX);
            end else begin
                ins_after = (idx == INS_IDX);
            end
        end
    end

endmodule

// File: rtl/cwm_pair_pack.sv
module cwm_pair_pack #(
    parameter int BYTE_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                last,
    input  logic                ins_after,
    input  logic                narrow,
    input  logic                swap,
    output logic                out_valid,
    output logic [2*BYTE_W-1:0] out_word,
    output logic                out_sop,
    output logic                out_eoc
);

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] held;
        logic              first;
        logic              ov;
        logic [WORD_W-1:0] word;
        logic              sop;
        logic              eoc;
    } pk_t;

    pk_t               p_q, p_d;
    logic              emit;
    logic [BYTE_W-1:0] b_first, b_second;

    always_comb begin
        p_d      = p_q;
        p_d.ov   = 1'b0;
        p_d.sop  = 1'b0;
        p_d.eoc  = 1'b0;
        emit     = 1'b0;
        b_first  = '0;
        b_second = '0;
        if (take) begin
            if (narrow) begin
                emit    = 1'b1;
                b_first = byte_in;
            end else if (!p_q.pend) begin
                if (ins_after || last) begin
                    emit    = 1'b1;
                    b_first = byte_in;
                end else begin
                    p_d.pend = 1'b1;
                    p_d.held = byte_in;
                end
            end else begin
                emit     = 1'b1;
                b_first  = p_q.held;
                b_second = byte_in;
                p_d.pend = ins_after;
                p_d.held = '0;
            end
        end
        if (emit) begin
            p_d.ov    = 1'b1;
            p_d.word  = (narrow || !swap) ? {b_second, b_first} : {b_first, b_second};
            p_d.sop   = p_q.first;
            p_d.eoc   = last;
            p_d.first = last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q       <= '0;
            p_q.first <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid = p_q.ov;
    assign out_word  = p_q.word;
    assign out_sop   = p_q.sop;
    assign out_eoc   = p_q.eoc;

    AST_VALID_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst)
        p_q.ov |-> $past(take)); // R11

    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (p_q.ov && $past(narrow)) |-> (p_q.word[WORD_W-1:BYTE_W] == '0)); // R2

    AST_PEND_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
        $past(take && last) |-> !p_q.pend); // R5

    AST_SOP_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
        (p_q.ov && p_q.eoc) |=> (!p_q.ov || p_q.sop)); // R8

endmodule

// File: rtl/cell_width_matcher.sv
module cell_width_matcher
    import cwm_pkg::*;
#(
    parameter  int BYTE_W   = 9,
    parameter  int MAX_CELL = 128,
    parameter  int DEL_POS  = 5,
    parameter  int INS_POS  = 6,
    localparam int CNT_W    = $clog2(MAX_CELL + 1),
    localparam int WORD_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [CNT_W-1:0]  cell_bytes,
    input  logic              bus_narrow,
    input  logic              lane_swap,
    input  logic              edit_en,
    input  logic              tx_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_sop,
    output logic              out_eoc
);

    cell_cfg_t        cfg_live, cfg_cell;
    logic             accept, last, drop, ins_after, take;
    logic [CNT_W-1:0] idx;

    assign cfg_live = '{narrow: bus_narrow, edit_en: edit_en, tx: tx_mode};

    cwm_cell_track #(.CNT_W(CNT_W)) i_track (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .cell_bytes (cell_bytes),
        .cfg_in     (cfg_live),
        .accept     (accept),
        .idx        (idx),
        .last       (last),
        .cfg_o      (cfg_cell)
    );

    cwm_edit_plan #(.CNT_W(CNT_W), .DEL_POS(DEL_POS), .INS_POS(INS_POS)) i_plan (
        .idx       (idx),
        .cfg       (cfg_cell),
        .drop      (drop),
        .ins_after (ins_after)
    );

    assign take = accept && !drop;

    cwm_pair_pack #(.BYTE_W(BYTE_W)) i_pack (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .byte_in   (in_byte),
        .last      (last),
        .ins_after (ins_after),
        .narrow    (cfg_cell.narrow),
        .swap      (lane_swap),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_sop   (out_sop),
        .out_eoc   (out_eoc)
    );

endmodule

// File: tb/test_cell_width_matcher.sv
module test_cell_width_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [8:0]  in_byte = '0;
    logic [7:0]  cell_bytes = 8'd8;
    logic        bus_narrow = 1'b0;
    logic        lane_swap = 1'b0;
    logic        edit_en = 1'b0;
    logic        tx_mode = 1'b0;
    logic        out_valid;
    logic [17:0] out_word;
    logic        out_sop;
    logic        out_eoc;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [17:0] w;
        logic        sop;
        logic        eoc;
        int          due;
        string       tag;
    } exp_t;

    exp_t expq[$];

    cell_width_matcher i_cell_width_matcher (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
        .cell_bytes(cell_bytes), .bus_narrow(bus_narrow), .lane_swap(lane_swap),
        .edit_en(edit_en), .tx_mode(tx_mode), .out_valid(out_valid), .out_word(out_word),
        .out_sop(out_sop), .out_eoc(out_eoc)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] bval(int cid, int i);
        return 9'(((cid * 37 + i * 11 + 1) % 511) + 1);
    endfunction

    function automatic logic swap_at(int pat, int i);
        case (pat)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return i[0];
            default: return i[1] ^ i[2];
        endcase
    endfunction

    task automatic check(bit ok, string msg, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R11 unexpected word", int'(out_word), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(out_word == e.w, {e.tag, " word (R3 R4 R10)"}, int'(out_word), int'(e.w));
                check(out_sop == e.sop && out_eoc == e.eoc, {e.tag, " R8 sop/eoc"},
                      int'({out_sop, out_eoc}), int'({e.sop, e.eoc}));
                check(cyc == e.due, {e.tag, " R11 timing"}, cyc, e.due);
            end
        end
    end

    task automatic run_cell(int n, bit nar, bit ed, bit tx, int pat, int cid, string tag, bit gap);
        logic [8:0] ab[$];
        int         src[$];
        int         nw;
        int         k;
        for (int i = 0; i < n; i++) begin
            if (!nar && ed && tx && i == 4) continue;
            ab.push_back(bval(cid, i));
            src.push_back(i);
            if (!nar && ed && !tx && i == 4) begin
                ab.push_back(9'd0);
                src.push_back(i);
            end
        end
        if (!nar && (ab.size() % 2 == 1)) begin
            ab.push_back(9'd0);
            src.push_back(n - 1);
        end
        nw = nar ? ab.size() : ab.size() / 2;
        k  = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sop    = (i == 0) || (i == 3);
            in_byte   = bval(cid, i);
            lane_swap = swap_at(pat, i);
            if (i == 0) begin
                cell_bytes = 8'(n); bus_narrow = nar; edit_en = ed; tx_mode = tx;
            end else begin
                cell_bytes = 8'(n + 5); bus_narrow = !nar; edit_en = !ed; tx_mode = !tx;
            end
            while (k < nw && (nar ? src[k] : src[2*k+1]) == i) begin
                exp_t e;
                if (nar) begin
                    e.w = {9'd0, ab[k]};
                end else if (swap_at(pat, src[2*k+1])) begin
                    e.w = {ab[2*k], ab[2*k+1]};
                end else begin
                    e.w = {ab[2*k+1], ab[2*k]};
                end
                e.sop = (k == 0);
                e.eoc = (k == nw - 1);
                e.due = cyc + 1;
                e.tag = tag;
                expq.push_back(e);
                k++;
            end
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b1;
                in_byte  = 9'h1FF;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        repeat (2) @(negedge clk);
        check(expq.size() == 0, {tag, " R8 word count"}, expq.size(), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cid;
        int nz;
        cid = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_sop == 1'b0 && out_eoc == 1'b0, "R1 reset outputs",
              int'({out_valid, out_sop, out_eoc}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

        // R9: bytes without a start flag outside a cell are dropped
        nz = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_byte = 9'(i + 3);
            if (out_valid) nz++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (out_valid) nz++;
        @(negedge clk);
        if (out_valid) nz++;
        check(nz == 0, "R9 stray bytes", nz, 0);
        run_cell(9, 1'b0, 1'b0, 1'b0, 0, cid++, "R9", 1'b0);

        // R2: narrow pass-through, edit and swap settings irrelevant
        for (int pat = 0; pat < 4; pat++) begin
            run_cell(8,  1'b1, pat[0], pat[1], pat, cid++, "R2", 1'b0);
            run_cell(13, 1'b1, 1'b1, 1'b0, pat, cid++, "R2", 1'b1);
            run_cell(53, 1'b1, 1'b1, 1'b1, pat, cid++, "R2", pat[0]);
        end

        // R5 R6 R7: wide sweep over sizes, edit modes and swap patterns
        for (int ed = 0; ed < 2; ed++) begin
            for (int tx = 0; tx < 2; tx++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    string tg;
                    tg = (ed == 0) ? "R5" : ((tx == 1) ? "R6" : "R7");
                    for (int n = 8; n <= 17; n++) begin
                        run_cell(n, 1'b0, ed[0], tx[0], pat, cid++, tg, n[0]);
                    end
                    run_cell(53,  1'b0, ed[0], tx[0], pat, cid++, tg, 1'b0);
                    run_cell(54,  1'b0, ed[0], tx[0], pat, cid++, tg, 1'b1);
                    run_cell(126, 1'b0, ed[0], tx[0], pat, cid++, tg, 1'b0);
                    if (ed == 0) begin
                        run_cell(127, 1'b0, 1'b0, tx[0], pat, cid++, tg, 1'b0);
                        run_cell(128, 1'b0, 1'b0, tx[0], pat, cid++, tg, 1'b1);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule